// File: doc/BRIEF.md
# Device Description Byte Streamer

This block answers a "describe yourself" query in a capture instrument. When the command decoder in front of it raises a one-cycle start strobe, the block plays out a fixed description of the device, one byte at a time, on a valid/ready transmit port. The description is a sequence of tagged records:

- a device name string and a version string, each ending in a zero byte;
- two 32-bit values, the sample memory depth and the top sample rate in hertz, each sent with its high byte first;
- two one-byte values, the probe count and the protocol revision.

One zero byte closes the whole stream. The numeric contents are parameters. The byte table is computed from them when the design is elaborated, so no memory initialisation is needed.

The transmit port follows the usual back-pressure rules. When the block offers a byte, it keeps that byte and keeps valid high until it samples ready high on a clock edge. It then moves on by exactly one byte. Ready may stay low for any number of cycles, and a stall never drops or repeats a byte. Busy is high for the whole transfer, and a new query that arrives during a transfer is discarded. Every query plays the stream again from its first tag.

Top module: `devinfo_streamer`

## Requirements
- R1: After reset, tx_valid_o and busy_o are both low.
- R2: A start_i pulse sampled while busy_o is low makes tx_valid_o and busy_o high on the next cycle, and the first byte offered is the name tag 0x01.
- R3: With default parameters the stream is exactly these 33 bytes: 01 'S' 'a' 'm' 'p' 'l' 'e' 'C' 'o' 'r' 'e' 00 02 '3' '.' '0' '0' 00 21 00 00 60 00 23 0B EB C2 00 40 20 41 02 00.
- R4: Each of the two strings is followed by exactly one 0x00 byte before the next tag.
- R5: Each 32-bit field goes out high byte first: the depth 24576 as 00 00 60 00, and the rate 200000000 as 0B EB C2 00.
- R6: While tx_valid_o is high and tx_ready_i is low, tx_data_o and tx_valid_o keep their values into the next cycle.
- R7: Each clock edge where tx_valid_o and tx_ready_i are both high advances the stream by exactly one byte.
- R8: A start_i pulse while busy_o is high has no effect: the stream in progress continues without restarting.
- R9: In the cycle after the final 0x00 terminator is accepted, tx_valid_o and busy_o are low.
- R10: A later query replays the full stream from the 0x01 tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle query strobe |
| tx_data_o | output | 8 | Byte currently offered |
| tx_valid_o | output | 1 | A byte is offered |
| tx_ready_i | input | 1 | Receiver takes the byte at this edge |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The bench stalls the receiver for a different number of cycles before each byte. A design that moved on while ready was low would show a skipped byte, and one that stepped twice per handshake would lose every other byte. A query is injected in the middle of the stream. A block that restarted on it would offer 0x01 again where the name text should continue. The cycle after the terminator is checked, to catch a block that stays busy or wraps around into a second copy. A second query with ready held high then checks that the address pointer was returned to the first tag, and that back-to-back handshakes each move one byte.

// File: rtl/devinfo_pkg.sv
package devinfo_pkg;
  localparam logic [7:0] TAG_NAME  = 8'h01;
  localparam logic [7:0] TAG_VER   = 8'h02;
  localparam logic [7:0] TAG_DEPTH = 8'h21;
  localparam logic [7:0] TAG_RATE  = 8'h23;
  localparam logic [7:0] TAG_PROBE = 8'h40;
  localparam logic [7:0] TAG_PROTO = 8'h41;
  localparam logic [7:0] NUL       = 8'h00;

  localparam int NAME_CHARS = 10;
  localparam logic [NAME_CHARS*8-1:0] NAME_TEXT = "SampleCore";
  localparam int VER_CHARS = 4;
  localparam logic [VER_CHARS*8-1:0] VER_TEXT = "3.00";

  // tag+text+nul, twice; two tag+word; two tag+byte; terminator
  localparam int STREAM_LEN = (1 + NAME_CHARS + 1) + (1 + VER_CHARS + 1)
                            + 2 * 5 + 2 * 2 + 1;

  typedef enum logic {ST_IDLE, ST_SEND} seq_state_e;
endpackage

// File: rtl/devinfo_rom.sv
module devinfo_rom
  import devinfo_pkg::*;
#(
  parameter logic [31:0] SAMPLE_DEPTH = 32'd24576,
  parameter logic [31:0] MAX_RATE     = 32'd200000000,
  parameter logic [7:0]  PROBE_COUNT  = 8'd32,
  parameter logic [7:0]  PROTO_REV    = 8'd2,
  localparam int AW = $clog2(STREAM_LEN)
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    byte_o
);
  function automatic logic [7:0] entry(input int idx);
    int p;
    p = idx;
    if (p == 0) return TAG_NAME;
    p = p - 1;
    if (p < NAME_CHARS) return NAME_TEXT[(NAME_CHARS-1-p)*8 +: 8];
    p = p - NAME_CHARS;
    if (p == 0) return NUL;
    p = p - 1;
    if (p == 0) return TAG_VER;
    p = p - 1;
    if (p < VER_CHARS) return VER_TEXT[(VER_CHARS-1-p)*8 +: 8];
    p = p - VER_CHARS;
    if (p == 0) return NUL;
    p = p - 1;
    if (p == 0) return TAG_DEPTH;
    p = p - 1;
    if (p < 4) return SAMPLE_DEPTH[(3-p)*8 +: 8];
    p = p - 4;
    if (p == 0) return TAG_RATE;
    p = p - 1;
    if (p < 4) return MAX_RATE[(3-p)*8 +: 8];
    p = p - 4;
    if (p == 0) return TAG_PROBE;
    if (p == 1) return PROBE_COUNT;
    if (p == 2) return TAG_PROTO;
    if (p == 3) return PROTO_REV;
    return NUL;
  endfunction

  logic [7:0] table_w [STREAM_LEN];

  for (genvar g = 0; g < STREAM_LEN; g++) begin : g_entry
    assign table_w[g] = entry(g);
  end

  always_comb begin
    byte_o = NUL;
    if (int'(addr_i) < STREAM_LEN) byte_o = table_w[addr_i];
  end
endmodule

// File: rtl/devinfo_seq.sv
module devinfo_seq
  import devinfo_pkg::*;
#(
  parameter int LEN = STREAM_LEN,
  localparam int AW = $clog2(LEN),
  localparam logic [AW-1:0] LAST = AW'(LEN - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          ready_i,
  output logic [AW-1:0] addr_o,
  output logic          active_o
);
  seq_state_e state_q;
  logic [AW-1:0] addr_q;
  logic take;

  assign take = (state_q == ST_SEND) && ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SEND;
          addr_q  <= '0;
        end
        ST_SEND: if (take) begin
          if (addr_q == LAST) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o   = addr_q;
  assign active_o = (state_q == ST_SEND);
endmodule

// File: rtl/devinfo_streamer.sv
module devinfo_streamer
  import devinfo_pkg::*;
#(
  parameter logic [31:0] SAMPLE_DEPTH = 32'd24576,
  parameter logic [31:0] MAX_RATE     = 32'd200000000,
  parameter logic [7:0]  PROBE_COUNT  = 8'd32,
  parameter logic [7:0]  PROTO_REV    = 8'd2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic       busy_o
);
  localparam int AW = $clog2(STREAM_LEN);

  logic [AW-1:0] addr_w;
  logic          active_w;

  devinfo_seq #(.LEN(STREAM_LEN)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .ready_i  (tx_ready_i),
    .addr_o   (addr_w),
    .active_o (active_w)
  );

  devinfo_rom #(
    .SAMPLE_DEPTH (SAMPLE_DEPTH),
    .MAX_RATE     (MAX_RATE),
    .PROBE_COUNT  (PROBE_COUNT),
    .PROTO_REV    (PROTO_REV)
  ) rom_i (
    .addr_i (addr_w),
    .byte_o (tx_data_o)
  );

  assign tx_valid_o = active_w;
  assign busy_o     = active_w;
endmodule

// File: rtl/devinfo_streamer_chk.sv
module devinfo_streamer_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic       busy_o
);
  // R6: an offered byte that is not taken stays put
  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R2: query from idle opens the stream with the name tag
  assert_open_tag_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (tx_valid_o && busy_o && tx_data_o == 8'h01));

  // R9: busy only drops right after an accepted zero byte
  assert_end_on_nul_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(tx_valid_o && tx_ready_i && tx_data_o == 8'h00));

  // R1: outside reset, valid never stands without busy
  assert_valid_busy_R1: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> busy_o);

  // R8: a query mid-stream never forces the opening tag back
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !tx_ready_i) |=> $stable(tx_data_o));
endmodule

bind devinfo_streamer devinfo_streamer_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .busy_o     (busy_o)
);

// File: tb/devinfo_streamer_tb_top.sv
module devinfo_streamer_tb_top;
  localparam int N = 33;
  // R3 R4 R5: expected stream, walked by the vector loop
  localparam logic [7:0] EXP [N] = '{
    8'h01, "S", "a", "m", "p", "l", "e", "C", "o", "r", "e", 8'h00,
    8'h02, "3", ".", "0", "0", 8'h00,
    8'h21, 8'h00, 8'h00, 8'h60, 8'h00,
    8'h23, 8'h0B, 8'hEB, 8'hC2, 8'h00,
    8'h40, 8'h20, 8'h41, 8'h02, 8'h00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic tx_ready_i = 1'b0;
  logic [7:0] tx_data_o;
  logic tx_valid_o, busy_o;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  devinfo_streamer dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", tx_valid_o, 0);
    chk("R1 busy after reset", busy_o, 0);

    // first query, with stalls before each byte
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 valid", tx_valid_o, 1);
    chk("R2 busy", busy_o, 1);
    chk("R2 first tag", tx_data_o, 8'h01);
    for (int i = 0; i < N; i++) begin
      for (int s = 0; s < i % 3; s++) begin
        if (i == 5) start_i = 1'b1; // R8: query while busy
        @(negedge clk);
        start_i = 1'b0;
        chk("R6 held valid", tx_valid_o, 1);
        chk("R6 held byte / R8", tx_data_o, EXP[i]);
      end
      chk("R3 R4 R5 byte", tx_data_o, EXP[i]);
      chk("R7 valid", tx_valid_o, 1);
      tx_ready_i = 1'b1;
      @(negedge clk);
      tx_ready_i = 1'b0;
    end
    chk("R9 valid after end", tx_valid_o, 0);
    chk("R9 busy after end", busy_o, 0);
    repeat (3) @(negedge clk);
    chk("R9 stays idle", busy_o, 0);

    // second query, receiver always ready
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    tx_ready_i = 1'b1;
    for (int i = 0; i < N; i++) begin
      chk("R10 R7 replay byte", tx_data_o, EXP[i]);
      chk("R10 busy", busy_o, 1);
      @(negedge clk);
    end
    tx_ready_i = 1'b0;
    chk("R9 valid after replay", tx_valid_o, 0);

    // reset mid-stream returns to idle
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 valid after mid reset", tx_valid_o, 0);
    chk("R1 busy after mid reset", busy_o, 0);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule